// File: doc/BRIEF.md
# Partitioned Flash Command Front End

This block sits at the front of a model of a NOR-style flash device that is split into several read partitions. It watches bus write cycles, each carrying a partition address, a block address and an 8-bit command byte. From these it runs one state machine for the whole chip. That machine covers ready, a pending second cycle, buffered-program loading, program or erase busy, the two suspend states, and buffered-enhanced programming. It hands work to an external write-state-machine stub through a one-cycle start pulse with an operation code, and it watches that stub's busy line.

Each partition separately remembers where its reads should come from: the memory array, the identifier/query area, or the status register. A read strobe with a partition address returns that partition's selection one cycle later. The block also builds the 8-bit status byte from its error flags, the suspend state and the busy line. Array storage, program and erase timing, and the identifier tables live elsewhere.

Top module: `fcmd_top`

## Requirements
- R1: After reset every partition selects the array (rd_src code 0), chip_state is READY (code 0) and status reads 0x80 while wsm_busy is low. Chip state codes are: READY 0, PAIR 1, BP_COUNT 2, BP_DATA 3, BP_CONFIRM 4, PGM_BUSY 5, ERS_BUSY 6, PGM_SUSP 7, ERS_SUSP 8, SUSP_PAIR 9, BEFP 10.
- R2: A command write sets only the addressed partition's source. 0xFF selects array (0), 0x70 selects status (1), and both 0x90 and 0x98 select identifier/query (2). A read strobe returns the source with rd_valid high in the following cycle.
- R3: A partition keeps its source until a new source-setting command is written to it. Commands written to other partitions do not change it.
- R4: For two-cycle commands (0x40/0x10 program, 0x20 erase, 0x80 enhanced program, 0x60 lock setup, 0xBC blank check), a second cycle at a different partition sets status bit 3 and returns to READY without a start pulse. For erase, a second byte other than 0xD0 sets status bits 5 and 3.
- R5: 0xE9 leaves the partition source unchanged. It is followed by a count byte N, then N+1 data writes (each pulsing data_accept), then 0xD0 at the same partition. That 0xD0 issues start with op 3, enters PGM_BUSY and switches the partition to status.
- R6: During the count or data phase of a buffered program, a write to a block other than the one latched with 0xE9 sets status bit 4 and returns to READY without a data_accept pulse.
- R7: Confirm-type pairs issue one start pulse and leave the chip in READY. The pairs and their ops are: 0x60 then 0x01 (op 5 lock), 0x60 then 0xD0 (op 6 unlock), 0x60 then 0x2F (op 7 lock-down), 0x60 then 0x03 (op 8 configuration) and 0xBC then 0xD0 (op 9 blank check).
- R8: Status is {~busy, erase-suspended, erase error, program error, sequence error, program-suspended, 0, busy}, bit 7 down to bit 0. 0x50 clears bits 5..3 in READY only. In busy or suspend states it has no effect.
- R9: 0xB0 in PGM_BUSY or ERS_BUSY enters the matching suspend state (7 or 8), and 0xD0 resumes with op 10. A two-cycle opener written while suspended consumes the next write as its pair. That pair is rejected (bit 3) and the chip stays suspended, so a 0xD0 used as a second cycle does not resume.
- R10: In BEFP (entered by 0x80 then 0xD0, op 4), a write to the latched block pulses data_accept only while status bit 0 (wsm_busy) is 0. A write to another block returns to READY.
- R11: A byte outside the supported set, or a command not valid in the present state, sets status bit 3. From READY the chip stays in READY. In busy or suspend states the chip state is kept.
- R12: The next chip state never depends on any partition's source selection.
- R13: PGM_BUSY and ERS_BUSY return to READY in the cycle after wsm_busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_part | input | PART_W | Partition address of the write |
| wr_blk | input | BLK_W | Block address of the write |
| wr_data | input | 8 | Command or data byte |
| rd_en | input | 1 | Read strobe |
| rd_part | input | PART_W | Partition address of the read |
| wsm_busy | input | 1 | Busy line from the write-state-machine stub |
| rd_valid | output | 1 | Read result valid, one cycle after rd_en |
| rd_src | output | 2 | Source for the read: 0 array, 1 status, 2 identifier/query |
| status | output | 8 | Status byte |
| chip_state | output | 4 | Chip command state code |
| wsm_start | output | 1 | One-cycle start pulse to the stub |
| wsm_op | output | 4 | Operation code that goes with wsm_start |
| data_accept | output | 1 | A buffered or enhanced program data write was taken |

## Verification
A wrong partition selection shows up only when that partition is read. The bench therefore reads the partition one cycle after each command and again after commands written to other partitions. A wrong chip state shows one cycle after the write that caused it, on chip_state, and often on wsm_start, wsm_op or the status error bits as well. The suspend and buffered-program tests push mis-sequenced or mis-addressed writes through the chip and check that the state does not drift. A missed suspend or abort then appears as a wrong state code or a stray start pulse within one cycle.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_STATUS = 2'd1,
        SRC_IDQ    = 2'd2
    } src_e;

    typedef enum logic [3:0] {
        ST_READY     = 4'd0,
        ST_PAIR      = 4'd1,
        ST_BP_COUNT  = 4'd2,
        ST_BP_DATA   = 4'd3,
        ST_BP_CONF   = 4'd4,
        ST_PGM_BUSY  = 4'd5,
        ST_ERS_BUSY  = 4'd6,
        ST_PGM_SUSP  = 4'd7,
        ST_ERS_SUSP  = 4'd8,
        ST_SUSP_PAIR = 4'd9,
        ST_BEFP      = 4'd10
    } chip_e;

    typedef enum logic [3:0] {
        OP_NONE    = 4'd0,
        OP_PGM     = 4'd1,
        OP_ERASE   = 4'd2,
        OP_BUFPGM  = 4'd3,
        OP_BEFP    = 4'd4,
        OP_LOCK    = 4'd5,
        OP_UNLOCK  = 4'd6,
        OP_LOCKDN  = 4'd7,
        OP_CFG     = 4'd8,
        OP_BLANK   = 4'd9,
        OP_RESUME  = 4'd10,
        OP_SUSPEND = 4'd11
    } op_e;

    typedef enum logic [3:0] {
        K_ILLEGAL,
        K_RD_ARRAY,
        K_RD_STATUS,
        K_RD_IDQ,
        K_CLEAR,
        K_PGM,
        K_ERASE,
        K_BUFPGM,
        K_BEFP,
        K_LOCKSET,
        K_BLANK,
        K_SUSPEND,
        K_CONFIRM
    } kind_e;

    localparam logic [7:0] CMD_CONFIRM = 8'hD0;

    function automatic kind_e classify(input logic [7:0] b);
        kind_e k;
        case (b)
            8'hFF:        k = K_RD_ARRAY;
            8'h70:        k = K_RD_STATUS;
            8'h90, 8'h98: k = K_RD_IDQ;
            8'h50:        k = K_CLEAR;
            8'h40, 8'h10: k = K_PGM;
            8'h20:        k = K_ERASE;
            8'hE9:        k = K_BUFPGM;
            8'h80:        k = K_BEFP;
            8'h60:        k = K_LOCKSET;
            8'hBC:        k = K_BLANK;
            8'hB0:        k = K_SUSPEND;
            CMD_CONFIRM:  k = K_CONFIRM;
            default:      k = K_ILLEGAL;
        endcase
        return k;
    endfunction

    function automatic logic opens_pair(input kind_e k);
        return (k == K_PGM) || (k == K_ERASE) || (k == K_BEFP) ||
               (k == K_LOCKSET) || (k == K_BLANK) || (k == K_BUFPGM);
    endfunction

    function automatic logic is_read_cmd(input kind_e k);
        return (k == K_RD_ARRAY) || (k == K_RD_STATUS) || (k == K_RD_IDQ);
    endfunction

    function automatic src_e src_of(input kind_e k);
        src_e s;
        case (k)
            K_RD_STATUS: s = SRC_STATUS;
            K_RD_IDQ:    s = SRC_IDQ;
            default:     s = SRC_ARRAY;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
    import fcmd_pkg::*;
(
    input  logic [7:0] byte_in,
    output kind_e      kind,
    output op_e        lock_op,
    output logic       lock_ok
);
    always_comb begin
        kind    = classify(byte_in);
        lock_ok = 1'b1;
        case (byte_in)
            8'h01:       lock_op = OP_LOCK;
            CMD_CONFIRM: lock_op = OP_UNLOCK;
            8'h2F:       lock_op = OP_LOCKDN;
            8'h03:       lock_op = OP_CFG;
            default: begin
                lock_op = OP_NONE;
                lock_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fcmd_partmux.sv
module fcmd_partmux
    import fcmd_pkg::*;
#(
    parameter int PART_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [PART_W-1:0] upd_part,
    input  src_e              upd_src,
    input  logic              rd_en,
    input  logic [PART_W-1:0] rd_part,
    output logic              rd_valid,
    output src_e              rd_src
);
    localparam int NPART = 1 << PART_W;

    logic [NPART-1:0][1:0] sel_vec;

    for (genvar p = 0; p < NPART; p++) begin : g_part
        src_e sel_q;
        always_ff @(posedge clk) begin
            if (rst)
                sel_q <= SRC_ARRAY;
            else if (upd_en && (upd_part == PART_W'(p)))
                sel_q <= upd_src;
        end
        assign sel_vec[p] = sel_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_src   <= SRC_ARRAY;
        end else begin
            rd_valid <= rd_en;
            rd_src   <= src_e'(sel_vec[rd_part]);
        end
    end
endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
    import fcmd_pkg::*;
#(
    parameter int PART_W = 3,
    parameter int BLK_W  = 10,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PART_W-1:0] wr_part,
    input  logic [BLK_W-1:0]  wr_blk,
    input  logic [7:0]        wr_data,
    input  kind_e             kind,
    input  op_e               lock_op,
    input  logic              lock_ok,
    input  logic              wsm_busy,
    output chip_e             state,
    output logic              err_seq,
    output logic              err_pgm,
    output logic              err_ers,
    output logic              susp_pgm,
    output logic              susp_ers,
    output logic              start,
    output op_e               op,
    output logic              accept,
    output logic              upd_en,
    output logic [PART_W-1:0] upd_part,
    output src_e              upd_src
);
    chip_e             st_n, ret_q, ret_n;
    kind_e             pend_q, pend_n;
    logic [PART_W-1:0] ppart_q, ppart_n;
    logic [BLK_W-1:0]  pblk_q, pblk_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic              eseq_n, epgm_n, eers_n;
    logic              start_n, acc_n, busy_q, busy_fell;
    op_e               op_n;
    logic              same_part, same_blk, is_conf;

    assign same_part = (wr_part == ppart_q);
    assign same_blk  = (wr_blk == pblk_q);
    assign is_conf   = (wr_data == CMD_CONFIRM);
    assign busy_fell = busy_q & ~wsm_busy;

    always_comb begin
        st_n    = state;
        ret_n   = ret_q;
        pend_n  = pend_q;
        ppart_n = ppart_q;
        pblk_n  = pblk_q;
        cnt_n   = cnt_q;
        eseq_n  = err_seq;
        epgm_n  = err_pgm;
        eers_n  = err_ers;
        start_n = 1'b0;
        op_n    = OP_NONE;
        acc_n   = 1'b0;
        upd_en  = 1'b0;
        upd_part = wr_part;
        upd_src = src_of(kind);

        if ((state == ST_PGM_BUSY || state == ST_ERS_BUSY) && busy_fell)
            st_n = ST_READY;

        if (wr_en) begin
            case (state)
                ST_READY: begin
                    if (is_read_cmd(kind)) begin
                        upd_en = 1'b1;
                    end else if (kind == K_CLEAR) begin
                        eseq_n = 1'b0;
                        epgm_n = 1'b0;
                        eers_n = 1'b0;
                    end else if (opens_pair(kind)) begin
                        st_n    = (kind == K_BUFPGM) ? ST_BP_COUNT : ST_PAIR;
                        pend_n  = kind;
                        ppart_n = wr_part;
                        pblk_n  = wr_blk;
                    end else begin
                        eseq_n = 1'b1;
                    end
                end
                ST_PAIR: begin
                    st_n = ST_READY;
                    if (!same_part) begin
                        eseq_n = 1'b1;
                    end else begin
                        case (pend_q)
                            K_PGM: begin
                                start_n = 1'b1;
                                op_n    = OP_PGM;
                                st_n    = ST_PGM_BUSY;
                                upd_en  = 1'b1;
                                upd_src = SRC_STATUS;
                            end
                            K_ERASE: begin
                                if (is_conf) begin
                                    start_n = 1'b1;
                                    op_n    = OP_ERASE;
                                    st_n    = ST_ERS_BUSY;
                                    upd_en  = 1'b1;
                                    upd_src = SRC_STATUS;
                                end else begin
                                    eseq_n = 1'b1;
                                    eers_n = 1'b1;
                                end
                            end
                            K_BEFP: begin
                                if (is_conf) begin
                                    start_n = 1'b1;
                                    op_n    = OP_BEFP;
                                    st_n    = ST_BEFP;
                                    upd_en  = 1'b1;
                                    upd_src = SRC_STATUS;
                                end else begin
                                    eseq_n = 1'b1;
                                end
                            end
                            K_LOCKSET: begin
                                if (lock_ok) begin
                                    start_n = 1'b1;
                                    op_n    = lock_op;
                                end else begin
                                    eseq_n = 1'b1;
                                end
                            end
                            K_BLANK: begin
                                if (is_conf) begin
                                    start_n = 1'b1;
                                    op_n    = OP_BLANK;
                                end else begin
                                    eseq_n = 1'b1;
                                end
                            end
                            default: eseq_n = 1'b1;
                        endcase
                    end
                end
                ST_BP_COUNT: begin
                    if (!same_blk) begin
                        epgm_n = 1'b1;
                        st_n   = ST_READY;
                    end else begin
                        cnt_n = wr_data[CNT_W-1:0];
                        st_n  = ST_BP_DATA;
                    end
                end
                ST_BP_DATA: begin
                    if (!same_blk) begin
                        epgm_n = 1'b1;
                        st_n   = ST_READY;
                    end else begin
                        acc_n = 1'b1;
                        if (cnt_q == '0)
                            st_n = ST_BP_CONF;
                        else
                            cnt_n = cnt_q - 1'b1;
                    end
                end
                ST_BP_CONF: begin
                    if (same_part && is_conf) begin
                        start_n = 1'b1;
                        op_n    = OP_BUFPGM;
                        st_n    = ST_PGM_BUSY;
                        upd_en  = 1'b1;
                        upd_src = SRC_STATUS;
                    end else begin
                        eseq_n = 1'b1;
                        st_n   = ST_READY;
                    end
                end
                ST_PGM_BUSY, ST_ERS_BUSY: begin
                    if (is_read_cmd(kind)) begin
                        upd_en = 1'b1;
                    end else if (kind == K_SUSPEND) begin
                        start_n = 1'b1;
                        op_n    = OP_SUSPEND;
                        st_n    = (state == ST_PGM_BUSY) ? ST_PGM_SUSP : ST_ERS_SUSP;
                    end else if (kind != K_CLEAR) begin
                        eseq_n = 1'b1;
                    end
                end
                ST_PGM_SUSP, ST_ERS_SUSP: begin
                    if (is_read_cmd(kind)) begin
                        upd_en = 1'b1;
                    end else if (kind == K_CONFIRM) begin
                        start_n = 1'b1;
                        op_n    = OP_RESUME;
                        st_n    = (state == ST_PGM_SUSP) ? ST_PGM_BUSY : ST_ERS_BUSY;
                    end else if (opens_pair(kind)) begin
                        ret_n = state;
                        st_n  = ST_SUSP_PAIR;
                    end else if (kind != K_CLEAR) begin
                        eseq_n = 1'b1;
                    end
                end
                ST_SUSP_PAIR: begin
                    eseq_n = 1'b1;
                    st_n   = ret_q;
                end
                ST_BEFP: begin
                    if (!same_blk)
                        st_n = ST_READY;
                    else if (!wsm_busy)
                        acc_n = 1'b1;
                end
                default: st_n = ST_READY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_READY;
            ret_q   <= ST_PGM_SUSP;
            pend_q  <= K_ILLEGAL;
            ppart_q <= '0;
            pblk_q  <= '0;
            cnt_q   <= '0;
            err_seq <= 1'b0;
            err_pgm <= 1'b0;
            err_ers <= 1'b0;
            start   <= 1'b0;
            op      <= OP_NONE;
            accept  <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            state   <= st_n;
            ret_q   <= ret_n;
            pend_q  <= pend_n;
            ppart_q <= ppart_n;
            pblk_q  <= pblk_n;
            cnt_q   <= cnt_n;
            err_seq <= eseq_n;
            err_pgm <= epgm_n;
            err_ers <= eers_n;
            start   <= start_n;
            op      <= op_n;
            accept  <= acc_n;
            busy_q  <= wsm_busy;
        end
    end

    assign susp_pgm = (state == ST_PGM_SUSP) ||
                      ((state == ST_SUSP_PAIR) && (ret_q == ST_PGM_SUSP));
    assign susp_ers = (state == ST_ERS_SUSP) ||
                      ((state == ST_SUSP_PAIR) && (ret_q == ST_ERS_SUSP));
endmodule

// File: rtl/fcmd_top.sv
module fcmd_top
    import fcmd_pkg::*;
#(
    parameter int PART_W = 3,
    parameter int BLK_W  = 10,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PART_W-1:0] wr_part,
    input  logic [BLK_W-1:0]  wr_blk,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [PART_W-1:0] rd_part,
    input  logic              wsm_busy,
    output logic              rd_valid,
    output logic [1:0]        rd_src,
    output logic [7:0]        status,
    output logic [3:0]        chip_state,
    output logic              wsm_start,
    output logic [3:0]        wsm_op,
    output logic              data_accept
);
    kind_e             kind;
    op_e               lock_op, op;
    logic              lock_ok;
    chip_e             state;
    logic              err_seq, err_pgm, err_ers, susp_pgm, susp_ers;
    logic              upd_en;
    logic [PART_W-1:0] upd_part;
    src_e              upd_src, src;

    fcmd_decode u_dec (
        .byte_in (wr_data),
        .kind    (kind),
        .lock_op (lock_op),
        .lock_ok (lock_ok)
    );

    fcmd_seq #(.PART_W(PART_W), .BLK_W(BLK_W), .CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_part  (wr_part),
        .wr_blk   (wr_blk),
        .wr_data  (wr_data),
        .kind     (kind),
        .lock_op  (lock_op),
        .lock_ok  (lock_ok),
        .wsm_busy (wsm_busy),
        .state    (state),
        .err_seq  (err_seq),
        .err_pgm  (err_pgm),
        .err_ers  (err_ers),
        .susp_pgm (susp_pgm),
        .susp_ers (susp_ers),
        .start    (wsm_start),
        .op       (op),
        .accept   (data_accept),
        .upd_en   (upd_en),
        .upd_part (upd_part),
        .upd_src  (upd_src)
    );

    fcmd_partmux #(.PART_W(PART_W)) u_mux (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (upd_en),
        .upd_part (upd_part),
        .upd_src  (upd_src),
        .rd_en    (rd_en),
        .rd_part  (rd_part),
        .rd_valid (rd_valid),
        .rd_src   (src)
    );

    assign rd_src     = src;
    assign wsm_op     = op;
    assign chip_state = state;
    assign status     = {~wsm_busy, susp_ers, err_ers, err_pgm,
                         err_seq, susp_pgm, 1'b0, wsm_busy};
endmodule

// File: rtl/fcmd_chk.sv
module fcmd_chk
    import fcmd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       rd_en,
    input logic       wsm_busy,
    input logic       rd_valid,
    input logic [7:0] status,
    input logic [3:0] chip_state,
    input logic       wsm_start,
    input logic [3:0] wsm_op,
    input logic       data_accept
);
    logic busy_or_susp;
    assign busy_or_susp = (chip_state == ST_PGM_BUSY) || (chip_state == ST_ERS_BUSY) ||
                          (chip_state == ST_PGM_SUSP) || (chip_state == ST_ERS_SUSP);

    a_r2_read_next_cycle: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    a_r8_clear_ignored_when_busy: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data == 8'h50 && busy_or_susp) |=> $stable(status[5:3]));

    a_r7_confirm_ends_ready: assert property (@(posedge clk) disable iff (rst)
        (wsm_start && (wsm_op == OP_LOCK || wsm_op == OP_UNLOCK || wsm_op == OP_LOCKDN ||
                       wsm_op == OP_CFG || wsm_op == OP_BLANK)) |-> chip_state == ST_READY);

    a_r9_pair_stays_suspended: assert property (@(posedge clk) disable iff (rst)
        (chip_state == ST_SUSP_PAIR && wr_en) |=>
            (chip_state == ST_PGM_SUSP || chip_state == ST_ERS_SUSP));

    a_r10_befp_gated_by_busy: assert property (@(posedge clk) disable iff (rst)
        (chip_state == ST_BEFP && wr_en && wsm_busy) |=> !data_accept);
endmodule

bind fcmd_top fcmd_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .wsm_busy    (wsm_busy),
    .rd_valid    (rd_valid),
    .status      (status),
    .chip_state  (chip_state),
    .wsm_start   (wsm_start),
    .wsm_op      (wsm_op),
    .data_accept (data_accept)
);

// File: tb/sim_fcmd_top.sv
module sim_fcmd_top;
    localparam int PW = 3;
    localparam int BW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [PW-1:0] wr_part = '0;
    logic [BW-1:0] wr_blk = '0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [PW-1:0] rd_part = '0;
    logic          wsm_busy = 1'b0;
    logic          rd_valid;
    logic [1:0]    rd_src;
    logic [7:0]    status;
    logic [3:0]    chip_state;
    logic          wsm_start;
    logic [3:0]    wsm_op;
    logic          data_accept;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fcmd_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_part(wr_part), .wr_blk(wr_blk),
        .wr_data(wr_data), .rd_en(rd_en), .rd_part(rd_part), .wsm_busy(wsm_busy),
        .rd_valid(rd_valid), .rd_src(rd_src), .status(status), .chip_state(chip_state),
        .wsm_start(wsm_start), .wsm_op(wsm_op), .data_accept(data_accept)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int part, input int blk, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_part = PW'(part); wr_blk = BW'(blk); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input int part, input int exp);
        @(negedge clk);
        rd_en = 1'b1; rd_part = PW'(part);
        @(negedge clk);
        rd_en = 1'b0;
        check({req, " rd_valid"}, int'(rd_valid), 1);
        check({req, " rd_src"}, int'(rd_src), exp);
    endtask

    task automatic busy_pulse();
        @(negedge clk); wsm_busy = 1'b1;
        @(negedge clk); wsm_busy = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 state", int'(chip_state), 0);
        check("R1 status", int'(status), 'h80);
        rd_check("R1 p0", 0, 0);
        rd_check("R1 p7", 7, 0);
    endtask

    task automatic t_read_modes();
        wr(1, 0, 8'h70);
        wr(4, 0, 8'h90);
        wr(2, 0, 8'h98);
        rd_check("R2 p1 status", 1, 1);
        rd_check("R2 p4 id", 4, 2);
        rd_check("R2 p2 query", 2, 2);
        rd_check("R3 p0 untouched", 0, 0);
        rd_check("R3 p1 revisit", 1, 1);
        wr(1, 0, 8'hFF);
        rd_check("R2 p1 array", 1, 0);
        rd_check("R3 p4 kept", 4, 2);
    endtask

    task automatic t_mismatch();
        wr(2, 5, 8'h40);
        wr(3, 5, 8'h12);
        check("R4 no start", int'(wsm_start), 0);
        check("R4 state", int'(chip_state), 0);
        check("R4 seq bit", int'(status[3]), 1);
        wr(0, 0, 8'h20);
        wr(0, 0, 8'hFF);
        check("R4 erase bits", int'(status[5:3]), 3'b101);
        wr(0, 0, 8'h50);
        check("R8 clear in ready", int'(status), 'h80);
    endtask

    task automatic t_bufpgm();
        wr(5, 7, 8'hE9);
        check("R5 state count", int'(chip_state), 2);
        rd_check("R5 src unchanged", 5, 0);
        wr(5, 7, 8'h02);
        check("R5 no accept on count", int'(data_accept), 0);
        check("R5 state data", int'(chip_state), 3);
        for (int i = 0; i < 3; i++) begin
            wr(5, 7, 8'(i));
            check("R5 data accept", int'(data_accept), 1);
        end
        check("R5 state confirm", int'(chip_state), 4);
        wr(5, 7, 8'hD0);
        check("R5 start", int'(wsm_start), 1);
        check("R5 op", int'(wsm_op), 3);
        check("R5 busy state", int'(chip_state), 5);
        rd_check("R5 src status", 5, 1);
        busy_pulse();
        check("R13 back to ready", int'(chip_state), 0);
    endtask

    task automatic t_bp_abort();
        wr(0, 3, 8'hE9);
        wr(0, 3, 8'h01);
        wr(0, 4, 8'h55);
        check("R6 no accept", int'(data_accept), 0);
        check("R6 pgm err", int'(status[4]), 1);
        check("R6 state", int'(chip_state), 0);
        wr(0, 0, 8'h50);
        wr(6, 3, 8'hE9);
        wr(6, 9, 8'h01);
        check("R6 count abort", int'(status[4]), 1);
        check("R6 state after count", int'(chip_state), 0);
        wr(0, 0, 8'h50);
    endtask

    task automatic t_confirm();
        logic [7:0] sec [4] = '{8'h01, 8'hD0, 8'h2F, 8'h03};
        for (int i = 0; i < 4; i++) begin
            wr(1, 2, 8'h60);
            wr(1, 2, sec[i]);
            check("R7 start", int'(wsm_start), 1);
            check("R7 op", int'(wsm_op), 5 + i);
            check("R7 ready", int'(chip_state), 0);
        end
        wr(3, 2, 8'hBC);
        wr(3, 2, 8'hD0);
        check("R7 blank op", int'(wsm_op), 9);
        check("R7 blank ready", int'(chip_state), 0);
    endtask

    task automatic t_erase_suspend();
        wr(6, 1, 8'h20);
        wr(6, 1, 8'hD0);
        check("R9 erase op", int'(wsm_op), 2);
        check("R9 erase busy", int'(chip_state), 6);
        @(negedge clk); wsm_busy = 1'b1;
        wr(6, 1, 8'h00);
        check("R11 busy keeps state", int'(chip_state), 6);
        check("R11 seq bit busy", int'(status[3]), 1);
        wr(6, 1, 8'hB0);
        check("R9 suspended", int'(chip_state), 8);
        wr(6, 1, 8'h50);
        check("R8 clear ignored", int'(status), 'h49);
        wr(6, 1, 8'h20);
        check("R9 pair pending", int'(chip_state), 9);
        wr(6, 1, 8'hD0);
        check("R9 lone confirm no resume", int'(chip_state), 8);
        check("R9 no start", int'(wsm_start), 0);
        wr(6, 1, 8'hD0);
        check("R9 resume op", int'(wsm_op), 10);
        check("R9 resumed", int'(chip_state), 6);
        @(negedge clk); wsm_busy = 1'b0;
        @(negedge clk);
        check("R13 ready", int'(chip_state), 0);
        wr(0, 0, 8'h50);
        check("R8 cleared", int'(status), 'h80);
    endtask

    task automatic t_illegal();
        wr(2, 0, 8'h00);
        check("R11 seq bit", int'(status[3]), 1);
        check("R11 state", int'(chip_state), 0);
        wr(2, 0, 8'h50);
    endtask

    task automatic t_befp();
        wr(3, 9, 8'h80);
        wr(3, 9, 8'hD0);
        check("R10 op", int'(wsm_op), 4);
        check("R10 state", int'(chip_state), 10);
        wr(3, 9, 8'h11);
        check("R10 accept idle", int'(data_accept), 1);
        @(negedge clk); wsm_busy = 1'b1;
        wr(3, 9, 8'h22);
        check("R10 ignored busy", int'(data_accept), 0);
        @(negedge clk); wsm_busy = 1'b0;
        wr(3, 2, 8'h33);
        check("R10 exit", int'(chip_state), 0);
    endtask

    task automatic t_indep();
        wr(0, 0, 8'h90);
        wr(0, 0, 8'h40);
        check("R12 pair after id", int'(chip_state), 1);
        wr(0, 0, 8'h77);
        check("R12 op", int'(wsm_op), 1);
        check("R12 state", int'(chip_state), 5);
        rd_check("R12 src status", 0, 1);
        busy_pulse();
        wr(7, 0, 8'h70);
        wr(7, 0, 8'h40);
        wr(7, 0, 8'h77);
        check("R12 same state", int'(chip_state), 5);
        busy_pulse();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_modes();
        t_mismatch();
        t_bufpgm();
        t_bp_abort();
        t_confirm();
        t_erase_suspend();
        t_illegal();
        t_befp();
        t_indep();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule